// File: doc/BRIEF.md
# Wait-State Parallel Bus Master

This block drives an external 8-bit parallel bus on behalf of a host. It runs two kinds of bus cycle: an address cycle that puts a small endpoint number on the bus under its own strobe, and a data cycle that moves one byte out of the block or into it. A cycle starts as a side effect of a register access. Writing the address register starts an address cycle. Writing the data register starts a data write. A read-request pulse starts a data read. A normal transfer therefore sends one address cycle and then one or more data cycles. Each strobe is stretched by a programmable wait-state count. In CPU mode the count is measured in ticks of a cycle clock that runs at one quarter of the system clock.

A busy flag covers every cycle. Software polls it between accesses. An access made while the flag is set is dropped and recorded in a sticky overrun bit. A completion flag, gated by an enable, raises an interrupt at the end of each CPU-owned cycle. An ownership input can pass the cycle-request path to a streaming source, which uses a valid/ready handshake. In that mode the wait states count system clocks, and the block reports each finished cycle with a one-clock done pulse instead of the interrupt flag.

Top module: `pbus_ctrl`

## Requirements
- R1: After reset, both strobes, `bus_dir`, `cpu_busy`, `cpu_ovr`, `cpu_irq_flag`, `st_done`, `cur_data` and `cur_addr` are all 0.
- R2: When the CPU owns the port and the block is idle, `cpu_addr_wr` starts an address cycle from the next clock. `bus_astb` rises. `bus_dir` is 1. `bus_dout` carries `cpu_wdata[3:0]` in bits 3:0 and zeros in bits 7:4. `cur_addr` takes that value.
- R3: When the CPU owns the port and the block is idle, `cpu_data_wr` alone starts a data write cycle. `bus_dstb` rises, `bus_dir` is 1 and `bus_dout` equals `cpu_wdata`. `cur_data` takes the written byte.
- R4: In CPU mode each strobe stays high for exactly (`cfg_wait`+1)*4 system clocks. `cpu_busy` is high for exactly the same clocks. At most one strobe is high at any time.
- R5: `cpu_rd_req` starts a data read cycle: `bus_dstb` is high and `bus_dir` is 0. The value on `bus_din` in the last strobe clock appears on `cur_data` once the strobe falls.
- R6: In the clock where a CPU-owned cycle ends, `cpu_irq_flag` is set. `cpu_irq` is `cpu_irq_flag` AND `irq_en`.
- R7: `cpu_irq_clr` clears the flag. If a cycle ends in the same clock as the clear, the flag stays set.
- R8: A CPU access made while busy, including in the last strobe clock, is ignored: no new cycle starts and `cur_data`/`cur_addr` keep their values. The access sets `cpu_ovr`, which stays set until `cpu_ovr_clr`. A set and a clear in the same clock leave the bit set.
- R9: While `cfg_en` is 0, no cycle starts, `st_ready` is 0 and requests do not set `cpu_ovr`.
- R10: With `cfg_own` = 1, CPU accesses are ignored and do not set `cpu_ovr`. `st_ready` is high when the block is enabled and idle. `st_valid` with `st_ready` starts a cycle chosen by `st_op`: 2'b00 data write, 2'b01 data read, 2'b1x address write.
- R11: In streaming mode a strobe lasts `cfg_wait`+1 clocks. `st_done` is high for the one clock after the strobe falls. `cpu_irq_flag` is not set.
- R12: `bus_dir` is 1 only while a write strobe is high, and it is 0 at every other time.
- R13: If several CPU access inputs are high in one idle clock, only one cycle starts. The address write wins over the data write, and the data write wins over the read. The losing accesses set `cpu_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Global enable; no cycle starts while 0 |
| cfg_own | input | 1 | 0: CPU register path requests cycles, 1: streaming source does |
| cfg_wait | input | 2 | Wait-state count per strobe |
| irq_en | input | 1 | Interrupt enable |
| cpu_addr_wr | input | 1 | Write address register (starts address cycle) |
| cpu_data_wr | input | 1 | Write data register (starts data write) |
| cpu_rd_req | input | 1 | Start a data read cycle |
| cpu_wdata | input | 8 | Write data for address or data register |
| cpu_ovr_clr | input | 1 | Clear overrun bit |
| cpu_irq_clr | input | 1 | Write-one clear of completion flag |
| cpu_busy | output | 1 | Cycle in progress |
| cpu_ovr | output | 1 | Sticky overrun status |
| cpu_irq_flag | output | 1 | Completion flag |
| cpu_irq | output | 1 | Interrupt request |
| cur_data | output | 8 | Data register contents |
| cur_addr | output | 4 | Address register contents |
| st_valid | input | 1 | Streaming request valid |
| st_op | input | 2 | Streaming cycle kind |
| st_wdata | input | 8 | Streaming write byte or address |
| st_ready | output | 1 | Streaming request can be accepted |
| st_done | output | 1 | Streaming cycle finished (one clock) |
| bus_astb | output | 1 | Address strobe, active high |
| bus_dstb | output | 1 | Data strobe, active high |
| bus_dir | output | 1 | 1 while the block drives `bus_dout` |
| bus_dout | output | 8 | Outgoing bus byte |
| bus_din | input | 8 | Incoming bus byte |

## Verification
Two pairs of events can land on the same clock edge. In the first pair, a cycle's final strobe clock can coincide with the software clear of the completion flag. In the second, it can coincide with a new register access, which the block still counts as arriving while busy. The bench knows the exact strobe length from `cfg_wait`, so it drives the clear or the access in precisely that last clock. It then checks that the flag survives and that the access is dropped with `cpu_ovr` set, and that `cur_data` is unchanged. A third collision is the overrun set meeting its clear. Several simultaneous CPU accesses are also provoked, and only the winning cycle is expected.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [1:0] {
      CYC_DWR = 2'b00,
      CYC_DRD = 2'b01,
      CYC_AWR = 2'b10
   } cyc_kind_e;
endpackage

// File: rtl/pbus_tick.sv
module pbus_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic fast,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         assign tick = fast | (cnt == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (restart)      cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pbus_arb.sv
module pbus_arb
   import pbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              own,
   input  logic              busy,
   input  logic              cpu_awr,
   input  logic              cpu_dwr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              st_valid,
   input  logic [1:0]        st_op,
   input  logic [DATA_W-1:0] st_wdata,
   output logic              st_ready,
   output logic              start,
   output cyc_kind_e         start_kind,
   output logic [DATA_W-1:0] start_data,
   output logic              ovr_evt
);
   logic cpu_any, cpu_multi, cpu_go, st_go;
   cyc_kind_e cpu_kind, st_kind;

   assign cpu_any   = cpu_awr | cpu_dwr | cpu_rd;
   assign cpu_multi = $countones({cpu_awr, cpu_dwr, cpu_rd}) > 1;
   assign cpu_go    = en & ~own & ~busy & cpu_any;
   assign st_ready  = en & own & ~busy;
   assign st_go     = st_ready & st_valid;

   always_comb begin
      if (cpu_awr)      cpu_kind = CYC_AWR;
      else if (cpu_dwr) cpu_kind = CYC_DWR;
      else              cpu_kind = CYC_DRD;
      if (st_op[1])     st_kind = CYC_AWR;
      else if (st_op[0]) st_kind = CYC_DRD;
      else              st_kind = CYC_DWR;
   end

   assign start      = cpu_go | st_go;
   assign start_kind = own ? st_kind : cpu_kind;
   assign start_data = own ? st_wdata : cpu_wdata;
   assign ovr_evt    = en & ~own & cpu_any & (busy | cpu_multi);

   a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);
   a_r10_own_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      (own && !st_valid) |-> !start);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
   import pbus_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int WS_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cyc_kind_e         kind,
   input  logic [DATA_W-1:0] wdata,
   input  logic [WS_W-1:0]   wait_n,
   input  logic              own,
   input  logic              tick,
   output logic              astb,
   output logic              dstb,
   output logic              dir,
   output logic [DATA_W-1:0] dout,
   output logic              busy,
   output logic              fin,
   output logic              fin_rd,
   output logic              cyc_st
);
   logic              act, is_addr, is_rd;
   logic [WS_W-1:0]   cnt;
   logic [DATA_W-1:0] addr_ext;

   generate
      if (DATA_W > ADDR_W) begin : g_pad
         assign addr_ext = {{(DATA_W-ADDR_W){1'b0}}, wdata[ADDR_W-1:0]};
      end else begin : g_nopad
         assign addr_ext = wdata;
      end
   endgenerate

   assign fin    = act & tick & (cnt == '0);
   assign fin_rd = fin & is_rd;
   assign busy   = act;
   assign astb   = act & is_addr;
   assign dstb   = act & ~is_addr;
   assign dir    = act & ~is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b0;
         is_addr <= 1'b0;
         is_rd   <= 1'b0;
         cnt     <= '0;
         dout    <= '0;
         cyc_st  <= 1'b0;
      end else if (start) begin
         act     <= 1'b1;
         is_addr <= (kind == CYC_AWR);
         is_rd   <= (kind == CYC_DRD);
         cnt     <= wait_n;
         cyc_st  <= own;
         if (kind == CYC_AWR)      dout <= addr_ext;
         else if (kind == CYC_DWR) dout <= wdata;
         else                      dout <= '0;
      end else if (fin) begin
         act <= 1'b0;
      end else if (act && tick) begin
         cnt <= cnt - 1'b1;
      end
   end

   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({astb, dstb}));
   a_r4_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !fin) |=> (act && $stable(is_addr) && $stable(is_rd)));
   a_r12_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (dir && !fin) |=> $stable(dout));
endmodule

// File: rtl/pbus_regs.sv
module pbus_regs
   import pbus_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cyc_kind_e         kind,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fin,
   input  logic              fin_rd,
   input  logic              fin_st,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              ovr_evt,
   input  logic              ovr_clr,
   input  logic              irq_clr,
   input  logic              irq_en,
   output logic [DATA_W-1:0] data_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              irq_flag,
   output logic              irq,
   output logic              ovr,
   output logic              st_done
);
   logic cpu_fin;
   assign cpu_fin = fin & ~fin_st;
   assign irq     = irq_flag & irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         addr_q   <= '0;
         irq_flag <= 1'b0;
         ovr      <= 1'b0;
         st_done  <= 1'b0;
      end else begin
         if (fin_rd)                          data_q <= bus_din;
         else if (start && kind == CYC_DWR)   data_q <= wdata;
         if (start && kind == CYC_AWR)        addr_q <= wdata[ADDR_W-1:0];
         if (cpu_fin)      irq_flag <= 1'b1;
         else if (irq_clr) irq_flag <= 1'b0;
         if (ovr_evt)      ovr <= 1'b1;
         else if (ovr_clr) ovr <= 1'b0;
         st_done <= fin & fin_st;
      end
   end

   a_r6_flag_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fin |=> irq_flag);
   a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !cpu_fin) |=> !irq_flag);
   a_r8_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> ovr);
   a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |=> !st_done);
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
   import pbus_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int WS_W   = 2,
   parameter int DIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_own,
   input  logic [WS_W-1:0]   cfg_wait,
   input  logic              irq_en,
   input  logic              cpu_addr_wr,
   input  logic              cpu_data_wr,
   input  logic              cpu_rd_req,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_ovr_clr,
   input  logic              cpu_irq_clr,
   output logic              cpu_busy,
   output logic              cpu_ovr,
   output logic              cpu_irq_flag,
   output logic              cpu_irq,
   output logic [DATA_W-1:0] cur_data,
   output logic [ADDR_W-1:0] cur_addr,
   input  logic              st_valid,
   input  logic [1:0]        st_op,
   input  logic [DATA_W-1:0] st_wdata,
   output logic              st_ready,
   output logic              st_done,
   output logic              bus_astb,
   output logic              bus_dstb,
   output logic              bus_dir,
   output logic [DATA_W-1:0] bus_dout,
   input  logic [DATA_W-1:0] bus_din
);
   generate
      if (ADDR_W > DATA_W) begin : g_chk_aw
         $error("pbus_ctrl: ADDR_W must not exceed DATA_W");
      end
      if (WS_W < 1 || WS_W > 8) begin : g_chk_ws
         $error("pbus_ctrl: WS_W out of range");
      end
      if (DIV < 1) begin : g_chk_div
         $error("pbus_ctrl: DIV must be at least 1");
      end
   endgenerate

   logic              start, ovr_evt, tick, fin, fin_rd, cyc_st;
   cyc_kind_e         start_kind;
   logic [DATA_W-1:0] start_data;

   pbus_arb #(.DATA_W(DATA_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .en(cfg_en), .own(cfg_own), .busy(cpu_busy),
      .cpu_awr(cpu_addr_wr), .cpu_dwr(cpu_data_wr), .cpu_rd(cpu_rd_req),
      .cpu_wdata(cpu_wdata), .st_valid(st_valid), .st_op(st_op),
      .st_wdata(st_wdata), .st_ready(st_ready), .start(start),
      .start_kind(start_kind), .start_data(start_data), .ovr_evt(ovr_evt)
   );

   pbus_tick #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(start), .fast(cyc_st), .tick(tick)
   );

   pbus_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WS_W(WS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(start_kind),
      .wdata(start_data), .wait_n(cfg_wait), .own(cfg_own), .tick(tick),
      .astb(bus_astb), .dstb(bus_dstb), .dir(bus_dir), .dout(bus_dout),
      .busy(cpu_busy), .fin(fin), .fin_rd(fin_rd), .cyc_st(cyc_st)
   );

   pbus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(start_kind),
      .wdata(start_data), .fin(fin), .fin_rd(fin_rd), .fin_st(cyc_st),
      .bus_din(bus_din), .ovr_evt(ovr_evt), .ovr_clr(cpu_ovr_clr),
      .irq_clr(cpu_irq_clr), .irq_en(irq_en), .data_q(cur_data),
      .addr_q(cur_addr), .irq_flag(cpu_irq_flag), .irq(cpu_irq),
      .ovr(cpu_ovr), .st_done(st_done)
   );

   a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !cpu_busy) |=> !cpu_busy);
   a_r12_dir_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dir |-> (bus_astb || bus_dstb));
endmodule

// File: tb/test_pbus_ctrl.sv
module test_pbus_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0, cfg_own = 1'b0, irq_en = 1'b0;
   logic [1:0] cfg_wait = 2'd0;
   logic cpu_addr_wr = 0, cpu_data_wr = 0, cpu_rd_req = 0;
   logic [7:0] cpu_wdata = 0;
   logic cpu_ovr_clr = 0, cpu_irq_clr = 0;
   logic cpu_busy, cpu_ovr, cpu_irq_flag, cpu_irq;
   logic [7:0] cur_data;
   logic [3:0] cur_addr;
   logic st_valid = 0;
   logic [1:0] st_op = 0;
   logic [7:0] st_wdata = 0;
   logic st_ready, st_done, bus_astb, bus_dstb, bus_dir;
   logic [7:0] bus_dout;
   logic [7:0] bus_din = 0;

   int checks = 0, errors = 0;
   logic [7:0] exp_data = 0;
   logic [3:0] exp_addr = 0;

   always #2 clk = ~clk;

   pbus_ctrl i_pbus_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_own(cfg_own),
      .cfg_wait(cfg_wait), .irq_en(irq_en), .cpu_addr_wr(cpu_addr_wr),
      .cpu_data_wr(cpu_data_wr), .cpu_rd_req(cpu_rd_req), .cpu_wdata(cpu_wdata),
      .cpu_ovr_clr(cpu_ovr_clr), .cpu_irq_clr(cpu_irq_clr), .cpu_busy(cpu_busy),
      .cpu_ovr(cpu_ovr), .cpu_irq_flag(cpu_irq_flag), .cpu_irq(cpu_irq),
      .cur_data(cur_data), .cur_addr(cur_addr), .st_valid(st_valid),
      .st_op(st_op), .st_wdata(st_wdata), .st_ready(st_ready), .st_done(st_done),
      .bus_astb(bus_astb), .bus_dstb(bus_dstb), .bus_dir(bus_dir),
      .bus_dout(bus_dout), .bus_din(bus_din)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_width(input int w, input bit st);
      return (w + 1) * (st ? 1 : 4);
   endfunction

   function automatic logic [7:0] exp_dout(input int op, input logic [7:0] v);
      if (op == 2) return {4'h0, v[3:0]};
      if (op == 0) return v;
      return 8'h00;
   endfunction

   function automatic bit strobe_of(input int op);
      return (op == 2) ? bus_astb : bus_dstb;
   endfunction

   task automatic measure(input int op, output int n);
      n = 0;
      while (strobe_of(op) && n < 100) begin
         n++;
         if (!cpu_busy) chk(0, "R4 busy during strobe", 0, 1);
         if (bus_dir !== (op != 1)) chk(0, "R12 dir during strobe", bus_dir, op != 1);
         @(negedge clk);
      end
   endtask

   // op: 0 data write, 1 read, 2 address write
   task automatic cpu_op(input int op, input logic [7:0] v, input int w, input bit ie);
      int n;
      cfg_wait = 2'(w); irq_en = ie; cpu_wdata = v; bus_din = ~v;
      cpu_data_wr = (op == 0); cpu_rd_req = (op == 1); cpu_addr_wr = (op == 2);
      @(negedge clk);
      cpu_data_wr = 0; cpu_rd_req = 0; cpu_addr_wr = 0;
      chk(strobe_of(op) === 1'b1, op == 2 ? "R2 astb rises" : (op == 0 ? "R3 dstb rises" : "R5 read dstb"), strobe_of(op), 1);
      if (op != 1) chk(bus_dout === exp_dout(op, v), op == 2 ? "R2 addr dout" : "R3 data dout", bus_dout, exp_dout(op, v));
      if (op == 2) exp_addr = v[3:0];
      else if (op == 0) exp_data = v;
      else exp_data = ~v;
      measure(op, n);
      chk(n == exp_width(w, 0), "R4 strobe width", n, exp_width(w, 0));
      chk(!cpu_busy && !bus_dir, "R12 idle after cycle", bus_dir, 0);
      chk(cpu_irq_flag === 1'b1, "R6 flag at end", cpu_irq_flag, 1);
      chk(cpu_irq === ie, "R6 irq gating", cpu_irq, ie);
      chk(cur_data === exp_data, op == 1 ? "R5 read capture" : "R3 data reg", cur_data, exp_data);
      chk(cur_addr === exp_addr, "R2 addr reg", cur_addr, exp_addr);
      cpu_irq_clr = 1; @(negedge clk); cpu_irq_clr = 0;
      chk(cpu_irq_flag === 1'b0, "R7 clear", cpu_irq_flag, 0);
   endtask

   initial begin
      int n;
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({bus_astb, bus_dstb, bus_dir, cpu_busy, cpu_ovr, cpu_irq_flag, st_done} == 7'b0, "R1 reset outputs", 0, 0);
      chk(cur_data == 0 && cur_addr == 0, "R1 reset regs", cur_data, 0);
      rst_n = 1;
      @(negedge clk);

      // R9 disabled
      cpu_wdata = 8'h5A; cpu_addr_wr = 1; cfg_own = 0;
      @(negedge clk); cpu_addr_wr = 0;
      repeat (3) begin
         chk(!bus_astb && !cpu_busy, "R9 no cycle when disabled", bus_astb, 0);
         @(negedge clk);
      end
      chk(!cpu_ovr && cur_addr == 0, "R9 no overrun when disabled", cpu_ovr, 0);
      cfg_own = 1;
      chk(st_ready === 1'b0, "R9 ready low when disabled", st_ready, 0);
      cfg_own = 0;
      cfg_en = 1;

      // directed cycles
      cpu_op(2, 8'hA7, 0, 1);
      cpu_op(0, 8'h3C, 3, 0);
      cpu_op(1, 8'h96, 1, 1);

      // R8 overrun during busy
      cfg_wait = 2'd1; cpu_wdata = 8'h11; cpu_data_wr = 1;
      @(negedge clk);
      cpu_wdata = 8'hEE;
      @(negedge clk);
      cpu_data_wr = 0;
      chk(cpu_ovr === 1'b1, "R8 overrun set", cpu_ovr, 1);
      measure(0, n);
      chk(n == 7, "R8 ignored write no restart", n, 7);
      chk(cur_data == 8'h11, "R8 data reg kept", cur_data, 8'h11);
      exp_data = 8'h11;
      repeat (2) @(negedge clk);
      chk(!cpu_busy, "R8 no new cycle", cpu_busy, 0);
      cpu_ovr_clr = 1; cpu_irq_clr = 1; @(negedge clk); cpu_ovr_clr = 0; cpu_irq_clr = 0;
      chk(cpu_ovr === 1'b0, "R8 overrun clear", cpu_ovr, 0);

      // R7 and R8 collisions in the final strobe clock
      cfg_wait = 2'd2; cpu_wdata = 8'h42; cpu_data_wr = 1;
      @(negedge clk); cpu_data_wr = 0;
      repeat (exp_width(2, 0) - 1) @(negedge clk);
      chk(bus_dstb === 1'b1, "R4 last strobe clock", bus_dstb, 1);
      cpu_irq_clr = 1; cpu_wdata = 8'h99; cpu_data_wr = 1;
      @(negedge clk);
      cpu_irq_clr = 0; cpu_data_wr = 0;
      chk(cpu_irq_flag === 1'b1, "R7 set wins over clear", cpu_irq_flag, 1);
      chk(cpu_ovr === 1'b1, "R8 write on last clock overruns", cpu_ovr, 1);
      chk(!bus_dstb && cur_data == 8'h42, "R8 last clock write ignored", cur_data, 8'h42);
      exp_data = 8'h42;
      // overrun set meets clear
      cfg_wait = 0; cpu_addr_wr = 1; cpu_wdata = 8'h05;
      @(negedge clk); cpu_addr_wr = 0;
      cpu_addr_wr = 1; cpu_ovr_clr = 1; cpu_wdata = 8'h0F;
      @(negedge clk); cpu_addr_wr = 0; cpu_ovr_clr = 0;
      chk(cpu_ovr === 1'b1, "R8 set wins over clear", cpu_ovr, 1);
      measure(2, n);
      chk(cur_addr == 4'h5, "R8 addr reg kept", cur_addr, 5);
      exp_addr = 4'h5;
      cpu_ovr_clr = 1; cpu_irq_clr = 1; @(negedge clk); cpu_ovr_clr = 0; cpu_irq_clr = 0;

      // R13 simultaneous accesses
      cpu_wdata = 8'hC3; cpu_addr_wr = 1; cpu_data_wr = 1; cpu_rd_req = 1;
      @(negedge clk); cpu_addr_wr = 0; cpu_data_wr = 0; cpu_rd_req = 0;
      chk(bus_astb && !bus_dstb, "R13 address wins", bus_astb, 1);
      chk(cpu_ovr === 1'b1, "R13 losers overrun", cpu_ovr, 1);
      measure(2, n);
      chk(cur_addr == 4'h3 && cur_data == exp_data, "R13 only winner applied", cur_data, exp_data);
      exp_addr = 4'h3;
      cpu_ovr_clr = 1; cpu_irq_clr = 1; @(negedge clk); cpu_ovr_clr = 0; cpu_irq_clr = 0;
      cpu_wdata = 8'h6B; cpu_data_wr = 1; cpu_rd_req = 1;
      @(negedge clk); cpu_data_wr = 0; cpu_rd_req = 0;
      chk(bus_dstb && bus_dir, "R13 write wins over read", bus_dir, 1);
      measure(0, n);
      exp_data = 8'h6B;
      cpu_ovr_clr = 1; cpu_irq_clr = 1; @(negedge clk); cpu_ovr_clr = 0; cpu_irq_clr = 0;

      // random CPU traffic
      for (int i = 0; i < 30; i++) begin
         int op = int'($urandom % 3);
         cpu_op(op, 8'($urandom), int'($urandom % 4), 1'($urandom));
      end

      // R10 / R11 streaming mode
      cfg_own = 1;
      cpu_wdata = 8'h77; cpu_data_wr = 1;
      @(negedge clk); cpu_data_wr = 0;
      chk(!cpu_busy && !cpu_ovr, "R10 CPU ignored when streaming", cpu_busy, 0);
      for (int i = 0; i < 20; i++) begin
         int op = int'($urandom % 4);
         int w = int'($urandom % 4);
         int kind = (op >= 2) ? 2 : op;
         logic [7:0] v = 8'($urandom);
         cfg_wait = 2'(w); st_op = 2'(op); st_wdata = v; bus_din = v ^ 8'h5A;
         chk(st_ready === 1'b1, "R10 ready when idle", st_ready, 1);
         st_valid = 1;
         @(negedge clk); st_valid = 0;
         chk(strobe_of(kind) === 1'b1, "R10 op decode", strobe_of(kind), 1);
         if (kind != 1) chk(bus_dout === exp_dout(kind, v), "R10 stream dout", bus_dout, exp_dout(kind, v));
         measure(kind, n);
         chk(n == exp_width(w, 1), "R11 stream width", n, exp_width(w, 1));
         chk(st_done === 1'b1, "R11 done pulse", st_done, 1);
         chk(cpu_irq_flag === 1'b0, "R11 no flag", cpu_irq_flag, 0);
         if (kind == 1) chk(cur_data == (v ^ 8'h5A), "R5 stream read capture", cur_data, v ^ 8'h5A);
         @(negedge clk);
         chk(st_done === 1'b0, "R11 done one clock", st_done, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule